// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the tag side of a cache with no timing beyond a single register stage. Each accepted request carries a byte address, an access size in bytes and a load/store flag. The block splits the address into a line address and a set index, compares every way of the indexed set in parallel, reports hit or miss, and updates the valid and dirty flags. On a miss it picks a victim way from a 32-bit pseudo-random generator, flags a writeback when the victim held modified data, and installs the new line in its place.

Seven running counters give read and write access counts, read and write miss counts, byte totals per direction and the number of writebacks. Parameters set the geometry, so one block serves as a direct-mapped instruction cache (1024 sets, 1 way, 32-byte lines), a two-way data cache (512 sets, 2 ways, 32-byte lines) or a fully associative translation buffer (1 set, 8 ways, 4096-byte pages). In the last role a parameter makes every lookup count as a read. The set count, the way count and the line size must each be a power of two.

Top module: `cache_tag_dir`

## Requirements
- R1: While reset is high, `req_ready` is 0, `rsp_valid` is 0 and all seven counters read 0. After reset, every line is invalid, so the first access to any address misses. `req_ready` is 1 whenever reset is low.
- R2: The set index is bits [OFF+IDX-1:OFF] of the address, where OFF = log2(LINE_BYTES) and IDX = log2(SETS). The stored tag is the full line address, which is the address shifted right by OFF. A request hits only when a valid way in its set holds the same line address. Two addresses in one line always hit each other, whatever the byte offset.
- R3: A store that hits marks the matching way dirty. A load that hits leaves every flag and the generator unchanged.
- R4: `rsp_way` reports the matching way on a hit and the victim way on a miss. The victim is the low log2(WAYS) bits of the generator value after its step for this miss, or way 0 when WAYS is 1.
- R5: The generator is 32 bits wide and resets to 1. One step shifts it right by one bit. When the bit shifted out was 1, the result is XORed with 0xD0000001. It steps exactly once for each miss and never on a hit.
- R6: A miss writes the new line address into the victim way with valid set and dirty cleared, even when the miss is a store.
- R7: `rsp_writeback` is 1 exactly when a miss evicts a way that was both valid and dirty. `cnt_wb` counts these events, and a hit never reports a writeback.
- R8: Every accepted request adds one to either the read or the write access counter, and every miss adds one to the matching miss counter. The counters hold their value in every cycle that has no response.
- R9: The byte counters add `req_size`, zero-extended, for each read or write access.
- R10: With FORCE_READ set, a store request is handled as a load. It never sets a dirty flag and it counts only in the read counters, so the write counters and `cnt_wb` stay at 0.
- R11: The response outputs and counters reflect a request on the clock edge that accepts it. `rsp_valid` is high for exactly the one cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (high out of reset) |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | SIZE_W | Access size in bytes |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Lookup hit |
| rsp_writeback | output | 1 | Evicted way was valid and dirty |
| rsp_way | output | max(1,log2(WAYS)) | Hit way or victim way |
| cnt_rd_acc | output | CNT_W | Read accesses |
| cnt_wr_acc | output | CNT_W | Write accesses |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_rd_bytes | output | CNT_W | Bytes read |
| cnt_wr_bytes | output | CNT_W | Bytes written |
| cnt_wb | output | CNT_W | Writebacks |

## Verification
A wrong tag or a wrong valid flag shows up as a wrong `rsp_hit` the next time that line is touched. A lost dirty flag stays hidden until that way is evicted, and then `rsp_writeback` and `cnt_wb` disagree with the expected values. A generator that steps on a hit or uses the wrong taps sends the next miss to the wrong `rsp_way`. Every later hit or miss in that set then diverges, usually within a few requests. Comparing all responses and counters after each request against an arithmetic model places the first divergence on the request that caused it.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned RNG_W = 32;
    localparam logic [RNG_W-1:0] RNG_SEED = 32'h0000_0001;
    localparam logic [RNG_W-1:0] RNG_TAPS = 32'hD000_0001;

    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    typedef struct packed {
        logic hit;
        logic evict_dirty;
    } lookup_res_t;

    // Field width for a count, never below one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // One Galois step: shift right, fold taps in when a one falls out.
    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
    endfunction
endpackage

// File: rtl/dir_victim_rng.sv
module dir_victim_rng
    import cache_dir_pkg::*;
#(
    parameter int unsigned WAYS = 2,
    localparam int unsigned WAY_W = width_of(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [WAY_W-1:0] victim
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [RNG_W-1:0] state_q;
    logic [RNG_W-1:0] state_nx;

    assign state_nx = rng_step(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RNG_SEED;
        end else if (advance) begin
            state_q <= state_nx;
        end
    end

    // The victim is taken from the value this miss steps to.
    generate
        if (WAYS > 1) begin : g_multi
            assign victim = state_nx[WAY_W-1:0];
        end else begin : g_single
            assign victim = '0;
        end
    endgenerate
endmodule

// File: rtl/dir_tag_array.sv
module dir_tag_array
    import cache_dir_pkg::*;
#(
    parameter int unsigned SETS  = 512,
    parameter int unsigned WAYS  = 2,
    parameter int unsigned TAG_W = 27,
    localparam int unsigned IDX_W = width_of(SETS),
    localparam int unsigned WAY_W = width_of(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             access,
    input  acc_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic [WAY_W-1:0] victim,
    output lookup_res_t      res,
    output logic [WAY_W-1:0] hit_way
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    line_flags_t      flags_q [SETS][WAYS];
    logic [WAYS-1:0]  match;

    // Parallel compare of every way; dirty plays no part.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = flags_q[idx][w].valid && (tag_q[idx][w] == tag);
        end
    endgenerate

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign res.hit         = |match;
    assign res.evict_dirty = flags_q[idx][victim].valid && flags_q[idx][victim].dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    flags_q[s][w] <= '0;
                end
            end
        end else if (access) begin
            if (res.hit) begin
                if (kind == KIND_STORE) flags_q[idx][hit_way].dirty <= 1'b1;
            end else begin
                flags_q[idx][victim] <= '{valid: 1'b1, dirty: 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (access && !res.hit) begin
            tag_q[idx][victim] <= tag;
        end
    end
endmodule

// File: rtl/dir_stats.sv
module dir_stats
    import cache_dir_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access,
    input  acc_kind_e         kind,
    input  logic              miss,
    input  logic              writeback,
    input  logic [SIZE_W-1:0] size,
    output logic [CNT_W-1:0]  rd_acc,
    output logic [CNT_W-1:0]  wr_acc,
    output logic [CNT_W-1:0]  rd_miss,
    output logic [CNT_W-1:0]  wr_miss,
    output logic [CNT_W-1:0]  rd_bytes,
    output logic [CNT_W-1:0]  wr_bytes,
    output logic [CNT_W-1:0]  wb
);
    timeunit 1ns;
    timeprecision 1ps;

    logic is_wr;
    logic [CNT_W-1:0] size_ext;

    assign is_wr    = (kind == KIND_STORE);
    assign size_ext = CNT_W'(size);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_acc   <= '0;
            wr_acc   <= '0;
            rd_miss  <= '0;
            wr_miss  <= '0;
            rd_bytes <= '0;
            wr_bytes <= '0;
            wb       <= '0;
        end else if (access) begin
            if (is_wr) begin
                wr_acc   <= wr_acc + 1'b1;
                wr_bytes <= wr_bytes + size_ext;
                if (miss) wr_miss <= wr_miss + 1'b1;
            end else begin
                rd_acc   <= rd_acc + 1'b1;
                rd_bytes <= rd_bytes + size_ext;
                if (miss) rd_miss <= rd_miss + 1'b1;
            end
            if (writeback) wb <= wb + 1'b1;
        end
    end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int unsigned SETS       = 512,
    parameter int unsigned WAYS       = 2,
    parameter int unsigned LINE_BYTES = 32,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned SIZE_W     = 4,
    parameter int unsigned CNT_W      = 32,
    parameter bit          FORCE_READ = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic                       req_store,
    output logic                       rsp_valid,
    output logic                       rsp_hit,
    output logic                       rsp_writeback,
    output logic [width_of(WAYS)-1:0]  rsp_way,
    output logic [CNT_W-1:0]           cnt_rd_acc,
    output logic [CNT_W-1:0]           cnt_wr_acc,
    output logic [CNT_W-1:0]           cnt_rd_miss,
    output logic [CNT_W-1:0]           cnt_wr_miss,
    output logic [CNT_W-1:0]           cnt_rd_bytes,
    output logic [CNT_W-1:0]           cnt_wr_bytes,
    output logic [CNT_W-1:0]           cnt_wb
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = width_of(SETS);
    localparam int unsigned WAY_W = width_of(WAYS);
    localparam int unsigned TAG_W = ADDR_W - OFF_W;

    logic             access;
    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] line_addr;
    logic [WAY_W-1:0] victim;
    logic [WAY_W-1:0] hit_way;
    lookup_res_t      res;
    logic             miss;
    logic             evict_wb;
    logic             unused_offset;

    assign req_ready = ~rst;
    assign access    = req_valid && req_ready;
    assign kind      = (req_store && !FORCE_READ) ? KIND_STORE : KIND_LOAD;
    assign line_addr = req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    generate
        if (SETS > 1) begin : g_indexed
            assign idx = req_addr[OFF_W +: IDX_W];
        end else begin : g_full_assoc
            assign idx = '0;
        end
    endgenerate

    assign miss     = !res.hit;
    assign evict_wb = miss && res.evict_dirty;

    dir_victim_rng #(.WAYS(WAYS)) u_rng (
        .clk     (clk),
        .rst     (rst),
        .advance (access && miss),
        .victim  (victim)
    );

    dir_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .access  (access),
        .kind    (kind),
        .idx     (idx),
        .tag     (line_addr),
        .victim  (victim),
        .res     (res),
        .hit_way (hit_way)
    );

    dir_stats #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_stats (
        .clk       (clk),
        .rst       (rst),
        .access    (access),
        .kind      (kind),
        .miss      (miss),
        .writeback (evict_wb),
        .size      (req_size),
        .rd_acc    (cnt_rd_acc),
        .wr_acc    (cnt_wr_acc),
        .rd_miss   (cnt_rd_miss),
        .wr_miss   (cnt_wr_miss),
        .rd_bytes  (cnt_rd_bytes),
        .wr_bytes  (cnt_wr_bytes),
        .wb        (cnt_wb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_writeback <= 1'b0;
            rsp_way       <= '0;
        end else begin
            rsp_valid <= access;
            if (access) begin
                rsp_hit       <= res.hit;
                rsp_writeback <= evict_wb;
                rsp_way       <= res.hit ? hit_way : victim;
            end
        end
    end
endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
    parameter int unsigned CNT_W      = 32,
    parameter bit          FORCE_READ = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_writeback,
    input logic [CNT_W-1:0] cnt_rd_acc,
    input logic [CNT_W-1:0] cnt_wr_acc,
    input logic [CNT_W-1:0] cnt_rd_miss,
    input logic [CNT_W-1:0] cnt_wr_miss,
    input logic [CNT_W-1:0] cnt_wb
);
    timeunit 1ns;
    timeprecision 1ps;

    // R11
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready));

    // R7
    wb_only_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_writeback) |-> !rsp_hit);

    // R8
    one_access_per_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((cnt_rd_acc + cnt_wr_acc) == ($past(cnt_rd_acc + cnt_wr_acc) + 1'b1)));

    // R8
    counters_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> ($stable(cnt_rd_acc) && $stable(cnt_wr_acc) && $stable(cnt_rd_miss)
                        && $stable(cnt_wr_miss) && $stable(cnt_wb)));

    // R8
    miss_within_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_miss <= cnt_rd_acc) && (cnt_wr_miss <= cnt_wr_acc));

    // R10
    no_writes_when_forced_chk: assert property (@(posedge clk) disable iff (rst)
        FORCE_READ |-> (cnt_wr_acc == '0 && cnt_wb == '0));
endmodule

bind cache_tag_dir dir_checker #(.CNT_W(CNT_W), .FORCE_READ(FORCE_READ)) u_dir_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_writeback (rsp_writeback),
    .cnt_rd_acc    (cnt_rd_acc),
    .cnt_wr_acc    (cnt_wr_acc),
    .cnt_rd_miss   (cnt_rd_miss),
    .cnt_wr_miss   (cnt_wr_miss),
    .cnt_wb        (cnt_wb)
);

// File: tb/test_cache_tag_dir.sv
module test_cache_tag_dir;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Small data-cache configuration: 4 sets, 2 ways, 16-byte lines.
    logic        a_valid = 1'b0, a_ready, a_store = 1'b0;
    logic [11:0] a_addr = '0;
    logic [3:0]  a_size = '0;
    logic        a_rv, a_hit, a_wbf;
    logic [0:0]  a_way;
    logic [31:0] a_rda, a_wra, a_rdm, a_wrm, a_rdb, a_wrb, a_wb;

    cache_tag_dir #(.SETS(4), .WAYS(2), .LINE_BYTES(16), .ADDR_W(12), .SIZE_W(4),
                    .CNT_W(32), .FORCE_READ(1'b0)) i_cache_tag_dir (
        .clk(clk), .rst(rst), .req_valid(a_valid), .req_ready(a_ready),
        .req_addr(a_addr), .req_size(a_size), .req_store(a_store),
        .rsp_valid(a_rv), .rsp_hit(a_hit), .rsp_writeback(a_wbf), .rsp_way(a_way),
        .cnt_rd_acc(a_rda), .cnt_wr_acc(a_wra), .cnt_rd_miss(a_rdm), .cnt_wr_miss(a_wrm),
        .cnt_rd_bytes(a_rdb), .cnt_wr_bytes(a_wrb), .cnt_wb(a_wb));

    // Translation-buffer configuration: 1 set, 8 ways, 4096-byte pages, all reads.
    logic        b_valid = 1'b0, b_ready, b_store = 1'b0;
    logic [19:0] b_addr = '0;
    logic [3:0]  b_size = '0;
    logic        b_rv, b_hit, b_wbf;
    logic [2:0]  b_way;
    logic [31:0] b_rda, b_wra, b_rdm, b_wrm, b_rdb, b_wrb, b_wb;

    cache_tag_dir #(.SETS(1), .WAYS(8), .LINE_BYTES(4096), .ADDR_W(20), .SIZE_W(4),
                    .CNT_W(32), .FORCE_READ(1'b1)) i_cache_tag_dir_tlb (
        .clk(clk), .rst(rst), .req_valid(b_valid), .req_ready(b_ready),
        .req_addr(b_addr), .req_size(b_size), .req_store(b_store),
        .rsp_valid(b_rv), .rsp_hit(b_hit), .rsp_writeback(b_wbf), .rsp_way(b_way),
        .cnt_rd_acc(b_rda), .cnt_wr_acc(b_wra), .cnt_rd_miss(b_rdm), .cnt_wr_miss(b_wrm),
        .cnt_rd_bytes(b_rdb), .cnt_wr_bytes(b_wrb), .cnt_wb(b_wb));

    // Reference state for the small cache.
    int          m_tag [4][2];
    bit          m_v   [4][2];
    bit          m_d   [4][2];
    logic [31:0] m_rng;
    longint      e_rda, e_wra, e_rdm, e_wrm, e_rdb, e_wrb, e_wb;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check_counters_a();
        chk("R8", "rd_acc", a_rda, e_rda);
        chk("R8", "wr_acc", a_wra, e_wra);
        chk("R8", "rd_miss", a_rdm, e_rdm);
        chk("R8", "wr_miss", a_wrm, e_wrm);
        chk("R9", "rd_bytes", a_rdb, e_rdb);
        chk("R9", "wr_bytes", a_wrb, e_wrb);
        chk("R7", "wb_count", a_wb, e_wb);
    endtask

    // One request on the small cache; tag names the requirement under focus.
    task automatic req_a(input logic [11:0] addr, input logic [3:0] sz, input bit st, input string tag);
        int  idx, la, way;
        bit  hit, wb;
        idx = (int'(addr) >> 4) & 3;
        la  = int'(addr) >> 4;
        hit = 0; way = 0; wb = 0;
        for (int w = 0; w < 2; w++) begin
            if (m_v[idx][w] && m_tag[idx][w] == la) begin
                hit = 1; way = w;
            end
        end
        if (hit) begin
            if (st) m_d[idx][way] = 1;              // R3
        end else begin
            m_rng = (m_rng >> 1) ^ (m_rng[0] ? 32'hD000_0001 : 32'h0);  // R5
            way = int'(m_rng[0]);                    // R4
            wb  = m_v[idx][way] && m_d[idx][way];
            m_tag[idx][way] = la;                    // R6: clean install
            m_v[idx][way] = 1;
            m_d[idx][way] = 0;
        end
        if (st) begin e_wra++; e_wrb += sz; if (!hit) e_wrm++; end
        else    begin e_rda++; e_rdb += sz; if (!hit) e_rdm++; end
        if (wb) e_wb++;

        @(negedge clk);
        chk("R11", "rsp_valid idle", a_rv, 0);
        a_valid = 1'b1; a_addr = addr; a_size = sz; a_store = st;
        @(negedge clk);
        a_valid = 1'b0;
        chk("R11", "rsp_valid", a_rv, 1);
        chk(tag, "hit", a_hit, hit);
        chk("R4/R5", "way", a_way, way);
        chk("R7", "writeback", a_wbf, wb);
        check_counters_a();
    endtask

    task automatic req_b(input logic [19:0] addr, input bit st, output bit hit);
        @(negedge clk);
        b_valid = 1'b1; b_addr = addr; b_size = 4'd8; b_store = st;
        @(negedge clk);
        b_valid = 1'b0;
        hit = b_hit;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        bit          bh;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = 0; m_v[s][w] = 0; m_d[s][w] = 0;
            end
        m_rng = 32'h1;
        e_rda = 0; e_wra = 0; e_rdm = 0; e_wrm = 0; e_rdb = 0; e_wrb = 0; e_wb = 0;

        // R1: state while reset is held
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", a_ready, 0);
        chk("R1", "rsp_valid in reset", a_rv, 0);
        check_counters_a();
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", a_ready, 1);

        // Directed: cold miss, same-line hit, conflict, store hit, store miss.
        req_a(12'h000, 4'd4, 1'b0, "R1");   // cold miss, way 1 from first step
        req_a(12'h00C, 4'd2, 1'b0, "R2");   // other offset, same line: hit
        req_a(12'h040, 4'd4, 1'b0, "R2");   // same set, new line: miss
        req_a(12'h044, 4'd8, 1'b1, "R3");   // store hit -> dirty
        req_a(12'h048, 4'd1, 1'b0, "R3");   // load hit, no change
        req_a(12'h090, 4'd4, 1'b1, "R6");   // store miss installs clean line
        req_a(12'h0D0, 4'd4, 1'b0, "R6");
        req_a(12'h110, 4'd4, 1'b0, "R6");   // further conflicts in set 1
        req_a(12'h150, 4'd4, 1'b0, "R6");
        req_a(12'h080, 4'd4, 1'b0, "R7");   // conflicts in set 0 may evict dirty line
        req_a(12'h0C0, 4'd4, 1'b0, "R7");
        req_a(12'h100, 4'd4, 1'b0, "R7");

        // Sweep every line address once with loads, then once with stores.
        for (int l = 0; l < 256; l++) req_a(12'(l << 4), 4'(l), 1'b0, "R2");
        for (int l = 0; l < 256; l++) req_a(12'((l << 4) | 4'h7), 4'(l + 3), 1'b1, "R2");

        // Mixed traffic over 32 lines to mix hits, misses and writebacks.
        seed = 32'h1234_5678;
        for (int k = 0; k < 1500; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            req_a({3'b000, seed[24:16]}, seed[11:8], seed[5], "R5");
        end

        // R10: stores on the translation buffer count as reads, never dirty.
        for (int p = 0; p < 12; p++) req_b(20'(p << 12), 1'b1, bh);
        req_b(20'(11 << 12) | 20'h123, 1'b1, bh);
        chk("R10", "latest page hit", bh, 1);
        chk("R10", "rd_acc", b_rda, 13);
        chk("R10", "rd_miss", b_rdm, 12);
        chk("R10", "rd_bytes", b_rdb, 104);
        chk("R10", "wr_acc", b_wra, 0);
        chk("R10", "wr_bytes", b_wrb, 0);
        chk("R10", "wr_miss", b_wrm, 0);
        chk("R10", "wb_count", b_wb, 0);

        @(negedge clk);
        chk("R11", "rsp_valid final idle", a_rv, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule